// File: doc/BRIEF.md
# Interrupt Arbitration and Vector Generator

This block keeps one pending-status bit for each interrupt line, masks the pending field with a local-enable mask, and decides whether the core may take an interrupt now. The decision uses a global interrupt-enable input and a debug-mode input. When an interrupt is taken, the block reports the winning line and the address of its handler. The handler address is formed from a programmable entry base and a programmable power-of-two vector spacing. Interrupt vectors sit past a fixed range of exception-code slots.

Line activity arrives as events. Each event carries a line number and a level. The enable mask, the spacing field and the entry base each have their own register-write port. A separate wake flag tells the core that an enabled interrupt is waiting, so the core can leave a halt. This flag does not look at the global enable or at debug mode.

Top module: `irq_vector_unit`

## Requirements
- R1: A line event with number n below NUM_LINES sets pending bit n when its level input is 1 and clears it when the level is 0. The new value is visible from the next cycle. Bit n belongs to line n.
- R2: Only lines whose bit in the enable mask is 1 count as pending. The mask is written through its write port and takes effect in the next cycle.
- R3: An interrupt is taken only when the masked pending field is nonzero, the global enable input is 1 and the debug-mode input is 0, all in the cycle before take_irq_o rises.
- R4: wake_o is 1 exactly when the masked pending field was nonzero in the previous cycle. It does not depend on the global enable or on debug mode.
- R5: When several masked lines are pending, the line with the highest number wins.
- R6: With a spacing field of 0, every interrupt vector equals the entry base.
- R7: With a spacing field f other than 0, the spacing is 4 << f bytes. The target address is base + (EXT_BASE + winner) * spacing, taken modulo 2^ADDR_W.
- R8: While rst_ni is low, the enable mask, spacing field, entry base and every pending bit are cleared, and all outputs are 0.
- R9: A line event whose number is NUM_LINES or more changes no state.
- R10: take_irq_o is a one-cycle pulse, one cycle after the take condition goes from false to true. win_idx_o and target_pc_o are registered, valid in the same cycle as the pulse, and held until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_vld_i | input | 1 | A line event is present |
| line_num_i | input | LINE_NUM_W | Line number of the event |
| line_lvl_i | input | 1 | Level of the line: 1 means nonzero |
| en_we_i | input | 1 | Write strobe for the enable mask |
| en_wdata_i | input | NUM_LINES | New enable mask |
| space_we_i | input | 1 | Write strobe for the spacing field |
| space_wdata_i | input | SPACE_W | New spacing field |
| base_we_i | input | 1 | Write strobe for the entry base |
| base_wdata_i | input | ADDR_W | New entry base |
| glb_ie_i | input | 1 | Global interrupt enable |
| dbg_mode_i | input | 1 | Core is in debug mode |
| take_irq_o | output | 1 | Take-interrupt pulse |
| wake_o | output | 1 | An enabled interrupt is pending (wake/has-work) |
| win_idx_o | output | IDX_W | Winning line number |
| target_pc_o | output | ADDR_W | Handler address |

## Verification
The bench uses the default parameters: 13 lines, a vector offset of 64, a 3-bit spacing field, a 32-bit address and a 5-bit line number. With a 5-bit line number, numbers 13 to 31 can be sent, so out-of-range events are exercised. The 3-bit field reaches every stride up to 512 bytes, including the zero stride. A base near the top of the 32-bit space makes the target address wrap around.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  // vectors are spaced in 4-byte units
  localparam int unsigned STRIDE_UNIT_LG2 = 2;

  function automatic int unsigned stride_lg2(input int unsigned field);
    return field + STRIDE_UNIT_LG2;
  endfunction
endpackage

// File: rtl/irq_state_regs.sv
module irq_state_regs #(
  parameter int unsigned NUM_LINES  = 13,
  parameter int unsigned LINE_NUM_W = 5,
  parameter int unsigned SPACE_W    = 3,
  parameter int unsigned ADDR_W     = 32
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_vld_i,
  input  logic [LINE_NUM_W-1:0] line_num_i,
  input  logic                  line_lvl_i,
  input  logic                  en_we_i,
  input  logic [NUM_LINES-1:0]  en_wdata_i,
  input  logic                  space_we_i,
  input  logic [SPACE_W-1:0]    space_wdata_i,
  input  logic                  base_we_i,
  input  logic [ADDR_W-1:0]     base_wdata_i,
  output logic [NUM_LINES-1:0]  pend_o,
  output logic [NUM_LINES-1:0]  en_o,
  output logic [SPACE_W-1:0]    space_o,
  output logic [ADDR_W-1:0]     base_o
);
  // one flop per line; out-of-range numbers match no bit
  for (genvar g = 0; g < NUM_LINES; g++) begin : g_pend
    logic hit;
    assign hit = line_vld_i && (line_num_i == LINE_NUM_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  pend_o[g] <= 1'b0;
      else if (hit) pend_o[g] <= line_lvl_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o    <= '0;
      space_o <= '0;
      base_o  <= '0;
    end else begin
      if (en_we_i)    en_o    <= en_wdata_i;
      if (space_we_i) space_o <= space_wdata_i;
      if (base_we_i)  base_o  <= base_wdata_i;
    end
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 13,
  parameter int unsigned IDX_W = 4
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // ascending scan: the last hit, which is the highest number, wins
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(N); i++) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
  parameter int unsigned IDX_W    = 4,
  parameter int unsigned SPACE_W  = 3,
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned EXT_BASE = 64
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [SPACE_W-1:0] space_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [ADDR_W-1:0]  pc_o
);
  import irq_arb_pkg::*;

  logic [ADDR_W-1:0] vec_num;
  logic [ADDR_W-1:0] offset;

  assign vec_num = ADDR_W'(EXT_BASE) + ADDR_W'(idx_i);

  always_comb begin
    if (space_i == '0) offset = '0;
    else               offset = vec_num << stride_lg2(int'(space_i));
  end

  assign pc_o = base_i + offset;
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit #(
  parameter int unsigned NUM_LINES  = 13,
  parameter int unsigned LINE_NUM_W = 5,
  parameter int unsigned SPACE_W    = 3,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned EXT_BASE   = 64,
  localparam int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  line_vld_i,
  input  logic [LINE_NUM_W-1:0] line_num_i,
  input  logic                  line_lvl_i,
  input  logic                  en_we_i,
  input  logic [NUM_LINES-1:0]  en_wdata_i,
  input  logic                  space_we_i,
  input  logic [SPACE_W-1:0]    space_wdata_i,
  input  logic                  base_we_i,
  input  logic [ADDR_W-1:0]     base_wdata_i,
  input  logic                  glb_ie_i,
  input  logic                  dbg_mode_i,
  output logic                  take_irq_o,
  output logic                  wake_o,
  output logic [IDX_W-1:0]      win_idx_o,
  output logic [ADDR_W-1:0]     target_pc_o
);
  logic [NUM_LINES-1:0] pend_q, en_q, masked;
  logic [SPACE_W-1:0]   space_q;
  logic [ADDR_W-1:0]    base_q;
  logic                 any_pend;
  logic [IDX_W-1:0]     pick_idx;
  logic [ADDR_W-1:0]    pick_pc;
  logic                 take_cond, take_cond_q;

  irq_state_regs #(
    .NUM_LINES(NUM_LINES), .LINE_NUM_W(LINE_NUM_W),
    .SPACE_W(SPACE_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk_i, .rst_ni, .line_vld_i, .line_num_i, .line_lvl_i,
    .en_we_i, .en_wdata_i, .space_we_i, .space_wdata_i,
    .base_we_i, .base_wdata_i,
    .pend_o(pend_q), .en_o(en_q), .space_o(space_q), .base_o(base_q)
  );

  assign masked = pend_q & en_q;

  irq_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .req_i(masked), .any_o(any_pend), .idx_o(pick_idx)
  );

  irq_vec_calc #(
    .IDX_W(IDX_W), .SPACE_W(SPACE_W), .ADDR_W(ADDR_W), .EXT_BASE(EXT_BASE)
  ) u_vec (
    .base_i(base_q), .space_i(space_q), .idx_i(pick_idx), .pc_o(pick_pc)
  );

  assign take_cond = any_pend && glb_ie_i && !dbg_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      take_cond_q <= 1'b0;
      take_irq_o  <= 1'b0;
      wake_o      <= 1'b0;
      win_idx_o   <= '0;
      target_pc_o <= '0;
    end else begin
      take_cond_q <= take_cond;
      take_irq_o  <= take_cond && !take_cond_q;
      wake_o      <= any_pend;
      if (take_cond && !take_cond_q) begin
        win_idx_o   <= pick_idx;
        target_pc_o <= pick_pc;
      end
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk #(
  parameter int unsigned NUM_LINES  = 13,
  parameter int unsigned LINE_NUM_W = 5,
  parameter int unsigned SPACE_W    = 3,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned IDX_W      = 4
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  line_vld_i,
  input logic [LINE_NUM_W-1:0] line_num_i,
  input logic                  glb_ie_i,
  input logic                  dbg_mode_i,
  input logic                  take_irq_o,
  input logic                  wake_o,
  input logic [IDX_W-1:0]      win_idx_o,
  input logic [ADDR_W-1:0]     target_pc_o,
  input logic [NUM_LINES-1:0]  pend_q,
  input logic [NUM_LINES-1:0]  en_q,
  input logic [SPACE_W-1:0]    space_q,
  input logic [ADDR_W-1:0]     base_q
);
  logic [NUM_LINES-1:0] masked_w;
  assign masked_w = pend_q & en_q;

  assert_take_gate_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> $past(glb_ie_i && !dbg_mode_i && (masked_w != '0)));

  assert_wake_free_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o == $past(masked_w != '0));

  assert_top_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |-> (($past(masked_w) >> win_idx_o) == NUM_LINES'(1)));

  assert_zero_stride_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_irq_o && ($past(space_q) == '0)) |-> (target_pc_o == $past(base_q)));

  assert_bad_line_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (line_vld_i && (int'(line_num_i) >= int'(NUM_LINES))) |=> $stable(pend_q));

  assert_one_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_irq_o |=> !take_irq_o);

  assert_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !take_irq_o |-> ($stable(win_idx_o) && $stable(target_pc_o)));
endmodule

bind irq_vector_unit irq_vector_unit_chk #(
  .NUM_LINES(NUM_LINES), .LINE_NUM_W(LINE_NUM_W), .SPACE_W(SPACE_W),
  .ADDR_W(ADDR_W), .IDX_W(IDX_W)
) u_chk (
  .clk_i, .rst_ni, .line_vld_i, .line_num_i, .glb_ie_i, .dbg_mode_i,
  .take_irq_o, .wake_o, .win_idx_o, .target_pc_o,
  .pend_q, .en_q, .space_q, .base_q
);

// File: tb/irq_vector_unit_tb_top.sv
`timescale 1ns/1ps
module irq_vector_unit_tb_top;
  localparam int NL  = 13;
  localparam int LW  = 5;
  localparam int SW  = 3;
  localparam int AW  = 32;
  localparam int EXT = 64;
  localparam int IW  = 4;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic line_vld_i = 0, line_lvl_i = 0, en_we_i = 0, space_we_i = 0, base_we_i = 0;
  logic glb_ie_i = 0, dbg_mode_i = 0;
  logic [LW-1:0] line_num_i = '0;
  logic [NL-1:0] en_wdata_i = '0;
  logic [SW-1:0] space_wdata_i = '0;
  logic [AW-1:0] base_wdata_i = '0;
  logic take_irq_o, wake_o;
  logic [IW-1:0] win_idx_o;
  logic [AW-1:0] target_pc_o;

  int errors = 0, checks = 0;
  int cycles = 0;

  // reference state
  bit [NL-1:0] m_pend, m_en;
  int m_space;
  longint m_base;
  bit m_take, m_wake, m_cond_q;
  int m_idx;
  longint m_pc;

  always #4 clk_i = ~clk_i;

  irq_vector_unit dut_i (
    .clk_i, .rst_ni, .line_vld_i, .line_num_i, .line_lvl_i,
    .en_we_i, .en_wdata_i, .space_we_i, .space_wdata_i,
    .base_we_i, .base_wdata_i, .glb_ie_i, .dbg_mode_i,
    .take_irq_o, .wake_o, .win_idx_o, .target_pc_o
  );

  function automatic int top_bit(input bit [NL-1:0] v);
    for (int i = NL - 1; i >= 0; i--) if (v[i]) return i;
    return 0;
  endfunction

  function automatic longint vec_addr(input longint b, input int f, input int idx);
    longint sp;
    sp = (f == 0) ? 0 : 4 * (longint'(1) << f);
    return (b + (EXT + idx) * sp) & 64'hFFFF_FFFF;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit cond;
    if (!rst_ni) begin
      m_pend = '0; m_en = '0; m_space = 0; m_base = 0;
      m_take = 0; m_wake = 0; m_cond_q = 0; m_idx = 0; m_pc = 0;
      return;
    end
    cond = ((m_pend & m_en) != 0) && glb_ie_i && !dbg_mode_i;
    m_take = cond && !m_cond_q;
    if (m_take) begin
      m_idx = top_bit(m_pend & m_en);
      m_pc  = vec_addr(m_base, m_space, m_idx);
    end
    m_cond_q = cond;
    m_wake = (m_pend & m_en) != 0;
    if (line_vld_i && int'(line_num_i) < NL) m_pend[line_num_i] = line_lvl_i;
    if (en_we_i) m_en = en_wdata_i;
    if (space_we_i) m_space = int'(space_wdata_i);
    if (base_we_i) m_base = longint'(base_wdata_i);
  endtask

  task automatic compare(input string ph);
    check({ph, " R3/R10 take"}, take_irq_o, m_take);
    check({ph, " R2/R4 wake"}, wake_o, m_wake);
    check({ph, " R5/R10 idx"}, win_idx_o, m_idx);
    check({ph, " R6/R7 pc"}, target_pc_o, m_pc);
  endtask

  task automatic cyc(input string ph);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    cycles++;
    compare(ph);
    line_vld_i = 0; en_we_i = 0; space_we_i = 0; base_we_i = 0;
  endtask

  task automatic line_ev(input int n, input bit lvl, input string ph);
    line_vld_i = 1; line_num_i = LW'(n); line_lvl_i = lvl;
    cyc(ph);
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R8: reset state
    repeat (2) @(negedge clk_i);
    model_edge();
    check("R8 take", take_irq_o, 0);
    check("R8 wake", wake_o, 0);
    check("R8 pc", target_pc_o, 0);
    rst_ni = 1;
    cyc("R8 idle");

    // R2: pending without enable stays invisible
    glb_ie_i = 1;
    line_ev(3, 1, "R2 masked");
    cyc("R2 masked");
    check("R2 wake masked", wake_o, 0);

    // program base, spacing, enable
    base_wdata_i = 32'h1000_0000; base_we_i = 1;
    space_wdata_i = 3'd1; space_we_i = 1;
    en_wdata_i = '1; en_we_i = 1;
    cyc("R7 cfg");
    cyc("R7 take3");
    check("R1 R10 take line3", take_irq_o, 1);
    check("R7 pc line3", target_pc_o, 64'h1000_0000 + 67 * 8);
    cyc("R10 held");
    check("R10 no repeat", take_irq_o, 0);

    // R5: higher line joins; no new pulse until condition drops
    line_ev(9, 1, "R5 add9");
    cyc("R5 add9");
    glb_ie_i = 0; cyc("R5 off");
    glb_ie_i = 1; cyc("R5 on");
    cyc("R5 take9");
    check("R5 idx line9", win_idx_o, 9);

    // R3/R4: debug mode blocks taking, wake still high
    glb_ie_i = 1; dbg_mode_i = 1;
    repeat (3) cyc("R3 dbg");
    check("R3 no take in debug", take_irq_o, 0);
    check("R4 wake in debug", wake_o, 1);
    dbg_mode_i = 0; glb_ie_i = 0;
    repeat (2) cyc("R4 gie0");
    check("R4 wake with gie0", wake_o, 1);

    // R6: zero spacing
    space_wdata_i = 0; space_we_i = 1; cyc("R6 cfg");
    glb_ie_i = 1; cyc("R6 on"); cyc("R6 take");
    check("R6 pc equals base", target_pc_o, 64'h1000_0000);

    // R1: clear lines by level 0
    glb_ie_i = 0;
    line_ev(9, 0, "R1 clr9");
    line_ev(3, 0, "R1 clr3");
    cyc("R1 clr");
    check("R1 wake after clear", wake_o, 0);

    // R9: out-of-range numbers ignored
    line_ev(13, 1, "R9 n13");
    line_ev(31, 1, "R9 n31");
    cyc("R9 idle");
    check("R9 wake after bad lines", wake_o, 0);

    // R7: wraparound with maximum spacing
    base_wdata_i = 32'hFFFF_FF00; base_we_i = 1;
    space_wdata_i = 3'd7; space_we_i = 1; cyc("R7 cfg2");
    line_ev(12, 1, "R7 wrap");
    glb_ie_i = 1; cyc("R7 wrap on"); cyc("R7 wrap take");
    check("R7 wrap pc", target_pc_o, vec_addr(64'hFFFF_FF00, 7, 12));

    // mixed traffic
    for (int k = 0; k < 4000; k++) begin
      line_vld_i = ($urandom % 3) == 0;
      line_num_i = LW'($urandom % 16);
      line_lvl_i = $urandom % 2;
      en_we_i = ($urandom % 40) == 0; en_wdata_i = NL'($urandom);
      space_we_i = ($urandom % 60) == 0; space_wdata_i = SW'($urandom);
      base_we_i = ($urandom % 60) == 0; base_wdata_i = $urandom;
      glb_ie_i = ($urandom % 4) != 0;
      dbg_mode_i = ($urandom % 10) == 0;
      cyc("R1..mix");
    end

    // R8: reset during activity
    en_wdata_i = '1; en_we_i = 1; cyc("R8 pre");
    line_ev(5, 1, "R8 pre");
    rst_ni = 0;
    @(negedge clk_i);
    model_edge();
    check("R8 mid take", take_irq_o, 0);
    check("R8 mid wake", wake_o, 0);
    check("R8 mid idx", win_idx_o, 0);
    rst_ni = 1;
    glb_ie_i = 1; dbg_mode_i = 0;
    en_wdata_i = '1; en_we_i = 1;
    cyc("R8 post"); cyc("R8 post");
    check("R8 pending cleared", wake_o, 0);

    finish_run();
  end
endmodule